// File: doc/BRIEF.md
# Delay-line phase step sequencer

The block moves a tunable delay line from one sampling phase to another. A one-cycle `start` loads a binary phase from 0 to 15. The block then drives a short series of read-modify-write updates on a control word. First it takes the output clock away from the recovery loop. It waits until the delay line reports that the output clock is off. It then loads the new select value, turns the output clock back on and waits until the delay line confirms it. Last, it returns control to the clock-data-recovery loop.

Each update is one cycle with `ctrl_we` high. `ctrl_wr` is formed from the current readback `ctrl_rd`, so the block changes only the bits it owns. Both waits have a fixed limit. If a wait runs out, the block gives up with an error pulse. When all four updates are complete, it gives a done pulse instead.

Top module: `phase_step_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `ctrl_we` are all 0.
- R2: The first update written after `start` clears bit 17 (recovery enable) and bit 18 (output clock enable). In the same word it sets bit 19 (external select enable) and bit 16 (delay-line enable).
- R3: The second update writes bits 23:20 with the reflected Gray code of the phase. The codes for phases 0 to 15 are 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8. This update is issued only after `ctrl_rd[18]` has been seen at 0.
- R4: The third update sets bit 18. The fourth update is issued only after `ctrl_rd[18]` has been seen at 1.
- R5: The fourth update sets bit 17 and clears bit 19. In the next cycle `done` is high for exactly one cycle and `busy` is low.
- R6: Each wait is limited to POLL_LIMIT × TICK_CYCLES cycles, which is 50 × 250 by default. When the limit runs out, `err` pulses for one cycle about that many cycles after the update that started the wait. No further update follows, and `done` stays low.
- R7: A `start` that arrives while `busy` is high has no effect. The phase of the sequence already running is kept, and no extra updates are issued.
- R8: In every update, all bits other than 16 to 23 are copied unchanged from `ctrl_rd`.
- R9: The wait budget reloads at the start of each wait. Each wait may use almost the whole limit, so one sequence may take longer in total than a single budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a phase change (accepted only when idle) |
| phase | input | 4 | Binary target phase, sampled with `start` |
| ctrl_rd | input | CTRL_W | Control word readback; bit 18 is the output clock status |
| ctrl_wr | output | CTRL_W | Control word to write |
| ctrl_we | output | 1 | Write strobe for `ctrl_wr` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on wait timeout |

## Verification
The hardest case to reach is a wait that ends just before its own limit, in both waits of the same sequence, which shows that the budget reloads. The behavioural responder in the bench echoes the output clock status with a programmable delay. A run sets that delay to 10000 cycles for each wait, so the sequence passes only if each wait receives a fresh budget of 12500 cycles. Timeouts are forced by holding the status stuck high, which stalls the first wait, or stuck low, which stalls the second.

// File: rtl/phase_step_seq.sv
module phase_step_seq #(
  parameter int CTRL_W      = 32,
  parameter int DLL_BIT     = 16,
  parameter int CDR_BIT     = 17,
  parameter int CKO_BIT     = 18,
  parameter int EXT_BIT     = 19,
  parameter int SEL_LSB     = 20,
  parameter int TICK_CYCLES = 250,
  parameter int POLL_LIMIT  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        phase,
  input  logic [CTRL_W-1:0] ctrl_rd,
  output logic [CTRL_W-1:0] ctrl_wr,
  output logic              ctrl_we,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int TW = $clog2(TICK_CYCLES + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [CTRL_W-1:0] M_DLL = CTRL_W'(1) << DLL_BIT;
  localparam logic [CTRL_W-1:0] M_CDR = CTRL_W'(1) << CDR_BIT;
  localparam logic [CTRL_W-1:0] M_CKO = CTRL_W'(1) << CKO_BIT;
  localparam logic [CTRL_W-1:0] M_EXT = CTRL_W'(1) << EXT_BIT;
  localparam logic [CTRL_W-1:0] M_SEL = CTRL_W'(4'hF) << SEL_LSB;

  typedef enum logic [2:0] {ST_IDLE, ST_CLR, ST_W0, ST_SEL, ST_CKON, ST_W1, ST_FIN} st_t;

  st_t           st;
  logic [3:0]    code_q;
  logic [TW-1:0] tick_q;
  logic [PW-1:0] poll_q;
  logic          done_q, err_q;

  wire cko_rb  = ctrl_rd[CKO_BIT];
  wire expired = (tick_q == '0) && (poll_q == '0);

  assign busy = (st != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;

  always_comb begin
    ctrl_we = 1'b1;
    ctrl_wr = ctrl_rd;
    case (st)
      ST_CLR:  ctrl_wr = (ctrl_rd & ~(M_CDR | M_CKO)) | M_EXT | M_DLL;
      ST_SEL:  ctrl_wr = (ctrl_rd & ~M_SEL) | (CTRL_W'(code_q) << SEL_LSB);
      ST_CKON: ctrl_wr = ctrl_rd | M_CKO;
      ST_FIN:  ctrl_wr = (ctrl_rd | M_CDR) & ~M_EXT;
      default: ctrl_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      code_q <= '0;
      tick_q <= '0;
      poll_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (tick_q != '0) tick_q <= tick_q - 1'b1;
      else begin
        tick_q <= TW'(TICK_CYCLES - 1);
        if (poll_q != '0) poll_q <= poll_q - 1'b1;
      end
      case (st)
        ST_IDLE: if (start) begin
          code_q <= phase ^ (phase >> 1);
          st     <= ST_CLR;
        end
        ST_CLR, ST_CKON: begin
          tick_q <= TW'(TICK_CYCLES - 1);
          poll_q <= PW'(POLL_LIMIT - 1);
          st     <= (st == ST_CLR) ? ST_W0 : ST_W1;
        end
        ST_W0: begin
          if (!cko_rb) st <= ST_SEL;
          else if (expired) begin st <= ST_IDLE; err_q <= 1'b1; end
        end
        ST_SEL: st <= ST_CKON;
        ST_W1: begin
          if (cko_rb) st <= ST_FIN;
          else if (expired) begin st <= ST_IDLE; err_q <= 1'b1; end
        end
        ST_FIN: begin st <= ST_IDLE; done_q <= 1'b1; end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !busy && !done && !err);
  p_sel_after_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && st == ST_SEL) |-> !$past(cko_rb));
  p_fin_after_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && st == ST_FIN) |-> $past(cko_rb));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_err_idle_r6: assert property (@(posedge clk) disable iff (!rst_n) err |-> !busy && !ctrl_we);
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done, err}));
  p_keep_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(code_q));
  p_keep_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |-> ((ctrl_wr ^ ctrl_rd) & ~(M_DLL | M_CDR | M_CKO | M_EXT | M_SEL)) == '0);
endmodule

// File: tb/test_phase_step_seq.sv
module test_phase_step_seq;
  localparam int B = 250 * 50;
  localparam logic [3:0] GRAY [16] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7, 4'h5, 4'h4,
                                       4'hC, 4'hD, 4'hF, 4'hE, 4'hA, 4'hB, 4'h9, 4'h8};
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{{4'd0, 12'd0}, {4'd1, 12'd3}, {4'd5, 12'd1}, {4'd7, 12'd12},
                                       {4'd10, 12'd0}, {4'd12, 12'd40}, {4'd15, 12'd2}, {4'd8, 12'd250}};

  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] phase = 0;
  logic [31:0] ctrl_rd, ctrl_wr;
  logic ctrl_we, busy, done, err;
  int checks = 0, errors = 0;

  logic [31:0] word = 32'h0;
  logic stat = 1'b1, tgt = 1'b1, load_req = 1'b0;
  logic [31:0] load_val = 0;
  int cnt = 0, lat = 0, stuck = 0;

  always #2 clk = ~clk;

  phase_step_seq i_phase_step_seq (.clk, .rst_n, .start, .phase, .ctrl_rd,
    .ctrl_wr, .ctrl_we, .busy, .done, .err);

  assign ctrl_rd = {word[31:19], stat, word[17:0]};

  always @(posedge clk) begin
    if (load_req) begin word <= load_val; stat <= load_val[18]; tgt <= load_val[18]; cnt <= 0; end
    else if (ctrl_we) begin word <= ctrl_wr; tgt <= ctrl_wr[18]; cnt <= lat; end
    else if (cnt != 0) cnt <= cnt - 1;
    else stat <= (stuck == 1) ? 1'b1 : (stuck == 2) ? 1'b0 : tgt;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual %h expected %h", req, act, exp); end
  endtask

  logic [31:0] wl [8];
  logic        rl [8];
  int nw, tw, tend;
  bit saw_done, saw_err, late_we;

  task automatic run(input logic [3:0] ph, input int l, input int s, input logic [31:0] init,
                     input int inject);
    @(negedge clk);
    lat = l; stuck = s; load_val = init | 32'h0004_0000; load_req = 1;
    @(negedge clk);
    load_req = 0; start = 1; phase = ph;
    @(negedge clk);
    start = 0; phase = ~ph;
    nw = 0; tw = 0; tend = 0; saw_done = 0; saw_err = 0; late_we = 0;
    for (int t = 0; t < 40000; t++) begin
      if (t == inject) start = 1; else start = 0;
      if (ctrl_we) begin
        if (nw < 8) begin wl[nw] = ctrl_wr; rl[nw] = ctrl_rd[18]; end
        nw++; tw = t;
      end
      if (done || err) begin
        saw_done = done; saw_err = err; tend = t;
        @(negedge clk);
        start = 0;
        chk(!done && !err && !busy, "R5 pulse one cycle", {done, err, busy}, 0);
        repeat (5) begin @(negedge clk); if (ctrl_we || done) late_we = 1; end
        break;
      end
      @(negedge clk);
    end
    start = 0;
  endtask

  task automatic check_ok(input logic [3:0] ph, input logic [31:0] init);
    logic [31:0] i0, e0, e1, e2, e3;
    i0 = init | 32'h0004_0000;
    e0 = (i0 & ~32'h0006_0000) | 32'h0009_0000;
    e1 = {e0[31:24], GRAY[ph], e0[19:0]};
    e2 = e1 | 32'h0004_0000;
    e3 = (e2 | 32'h0002_0000) & ~32'h0008_0000;
    chk(saw_done && !saw_err && nw == 4, "R5 done with four writes", nw, 4);
    chk(wl[0] == e0, "R2 R8 first write", wl[0], e0);
    chk(wl[1] == e1 && rl[1] == 1'b0, "R3 gray select after off", wl[1], e1);
    chk(wl[2] == e2, "R4 clock on write", wl[2], e2);
    chk(wl[3] == e3 && rl[3] == 1'b1, "R4 R5 final write after on", wl[3], e3);
    chk(!late_we, "R5 no writes after done", late_we, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !ctrl_we, "R1 reset state", {busy, done, err, ctrl_we}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !err && !ctrl_we, "R1 idle after reset", {busy, done, err, ctrl_we}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] ini;
      ini = 32'h5A6B_C3D2 ^ (v * 32'h1357_0101);
      run(VEC[v][15:12], int'(VEC[v][11:0]), 0, ini, -1);
      check_ok(VEC[v][15:12], ini);
    end

    for (int p = 0; p < 16; p++) begin
      run(4'(p), 0, 0, 32'hFFFF_FFFF, -1);
      chk(saw_done && wl[1][23:20] == GRAY[p], "R3 gray code all phases", wl[1][23:20], GRAY[p]);
    end

    run(4'd6, 30, 0, 32'h0123_4567, 4);
    check_ok(4'd6, 32'h0123_4567);
    chk(wl[1][23:20] == GRAY[6], "R7 start while busy ignored", wl[1][23:20], GRAY[6]);

    run(4'd9, B - 2500, 0, 32'h89AB_CDEF, -1);
    check_ok(4'd9, 32'h89AB_CDEF);
    chk(tend > B, "R9 budget reloads per wait", tend, B);

    run(4'd3, 0, 1, 32'h1111_2222, -1);
    chk(saw_err && !saw_done && nw == 1, "R6 timeout first wait", nw, 1);
    chk(tend - tw >= B && tend - tw <= B + 2, "R6 first wait bound", tend - tw, B + 1);
    chk(!late_we, "R6 no writes after err", late_we, 0);

    run(4'd11, 0, 2, 32'h3333_4444, -1);
    chk(saw_err && !saw_done && nw == 3, "R6 timeout second wait", nw, 3);
    chk(tend - tw >= B && tend - tw <= B + 2, "R6 second wait bound", tend - tw, B + 1);

    run(4'd2, 5, 0, 32'h7777_0000, -1);
    check_ok(4'd2, 32'h7777_0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule